// File: doc/BRIEF.md
# Pipeline Operand Interlock

This block decides how the instruction sitting in the register-read stage of a six-stage in-order scalar pipeline (fetch, decode, register read, execute, memory, write-back) gets its two source operands. Each cycle it compares the two source register numbers of that instruction against the destination numbers of the older instructions in execute, memory and write-back. When a matching result can be bypassed, it chooses a bypass path for each operand. When the matching result is a load that is still in execute, it holds the front end for one cycle and has the pipeline put an empty slot into execute.

The operand selects are registered. They change at the clock edge that moves the register-read instruction into execute, so the execute-stage multiplexers see them in the same cycle as the operands they steer. By that edge the execute-stage producer has moved into the memory stage and its result sits in the execute/memory latch, while the memory-stage producer has moved into write-back and its result sits in the memory/write-back latch. The stall and bubble outputs are combinational and apply to the current cycle. By default the register file returns a value written in the same cycle, so a write-back producer needs no action; a parameter switches this off, and a write-back-only match then stalls.

Top module: `hzd_interlock`

## Requirements
- R1: While reset is held and straight after its release, both operand selects read 00 (register file), and with all inputs zero stall_o and bubble_o are low.
- R2: If the execute-stage instruction writes register r (write enable set, r nonzero), is not a load, and r equals a source, then after the next clock edge that operand's select is 01 (execute/memory latch), with no stall.
- R3: If only the memory-stage instruction writes a matching nonzero register, then after the next edge that operand's select is 10 (memory/write-back latch).
- R4: When the execute-stage and memory-stage instructions both write the same matching register, the execute-stage (younger) producer wins and the select is 01.
- R5: A producer with write enable clear, or with destination 0, never causes a bypass or a stall, and a source of 0 always selects 00.
- R6: A load in the execute stage whose nonzero destination matches either source raises stall_o and bubble_o in that same cycle. A load that matches neither source raises neither.
- R7: After a stalled cycle, both selects are 00, so the empty slot entering execute uses no bypass.
- R8: In the cycle after a load-use stall, with the load now in the memory stage and an empty slot in execute, there is no stall and the dependent operand's select becomes 10.
- R9: With the default setting (the register file returns a same-cycle write), a match against the write-back stage alone gives select 00 and no stall.
- R10: The two operands are resolved independently, so each can get a different select in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_rs1_i | input | REG_W | First source register of the register-read instruction |
| rd_rs2_i | input | REG_W | Second source register of the register-read instruction |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | REG_W | Destination register of the write-back instruction |
| wb_wen_i | input | 1 | Write-back instruction writes a register |
| stall_o | output | 1 | Hold fetch, decode and register read this cycle |
| bubble_o | output | 1 | Put an empty slot into execute this cycle |
| fwd_a_o | output | 2 | First operand select for execute: 00 file, 01 execute/memory latch, 10 memory/write-back latch |
| fwd_b_o | output | 2 | Second operand select, same encoding |

## Verification
Several properties are checked on every cycle: a load-use match always raises both stall and bubble, a stalled cycle is always followed by plain register-file selects, an execute-stage match without a stall or a memory-only match leads to the right select one edge later, a zero source never bypasses, and the code 11 never appears. Other behaviour is shown only by the bench scenarios: the reset values, the priority when both stages write the same register, the handover from stall to memory-stage bypass as a load moves on, the quiet write-back match, and two operands taking different paths in the same cycle.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_src_cmp.sv
`timescale 1ns/1ps
module hzd_src_cmp
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W          = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wen_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wen_i,
  output fwd_sel_e         sel_o,
  output logic             hold_o
);
  logic src_live;
  logic ex_hit, mem_hit, wb_hit;

  assign src_live = |src_i;
  assign ex_hit   = src_live && ex_wen_i  && (ex_rd_i  == src_i);
  assign mem_hit  = src_live && mem_wen_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_wen_i  && (wb_rd_i  == src_i);

  // youngest producer first
  always_comb begin
    sel_o = FWD_RF;
    if (ex_hit)       sel_o = FWD_MEM;
    else if (mem_hit) sel_o = FWD_WB;
  end

  always_comb begin
    hold_o = ex_hit && ex_load_i;
    if (!RF_WRITE_FIRST && !ex_hit && !mem_hit && wb_hit) hold_o = 1'b1;
  end
endmodule

// File: rtl/hzd_sel_reg.sv
`timescale 1ns/1ps
module hzd_sel_reg
  import hzd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  fwd_sel_e sel_i,
  output fwd_sel_e sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_o <= FWD_RF;
    else if (flush_i) sel_o <= FWD_RF;  // bubble enters execute
    else              sel_o <= sel_i;
  end
endmodule

// File: rtl/hzd_interlock.sv
`timescale 1ns/1ps
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W          = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] rd_rs1_i,
  input  logic [REG_W-1:0] rd_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wen_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wen_i,
  output logic             stall_o,
  output logic             bubble_o,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o
);
  logic [REG_W-1:0] src  [NUM_SRC];
  fwd_sel_e         sel_d[NUM_SRC];
  fwd_sel_e         sel_q[NUM_SRC];
  logic [NUM_SRC-1:0] hold;
  logic             stall;

  assign src[0] = rd_rs1_i;
  assign src[1] = rd_rs2_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_src_cmp #(
      .REG_W         (REG_W),
      .RF_WRITE_FIRST(RF_WRITE_FIRST)
    ) u_cmp (
      .src_i    (src[g]),
      .ex_rd_i  (ex_rd_i),
      .ex_wen_i (ex_wen_i),
      .ex_load_i(ex_load_i),
      .mem_rd_i (mem_rd_i),
      .mem_wen_i(mem_wen_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wen_i (wb_wen_i),
      .sel_o    (sel_d[g]),
      .hold_o   (hold[g])
    );

    hzd_sel_reg u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(stall),
      .sel_i  (sel_d[g]),
      .sel_o  (sel_q[g])
    );
  end

  assign stall    = |hold;
  assign stall_o  = stall;
  assign bubble_o = stall;
  assign fwd_a_o  = sel_q[0];
  assign fwd_b_o  = sel_q[1];
endmodule

// File: rtl/hzd_interlock_chk.sv
`timescale 1ns/1ps
module hzd_interlock_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] rd_rs1_i,
  input logic [REG_W-1:0] rd_rs2_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_wen_i,
  input logic             ex_load_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_wen_i,
  input logic             stall_o,
  input logic             bubble_o,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o
);
  logic ex_live, ex_a, ex_b, mem_a;
  assign ex_live = ex_wen_i && (ex_rd_i != '0);
  assign ex_a    = ex_live && (ex_rd_i == rd_rs1_i);
  assign ex_b    = ex_live && (ex_rd_i == rd_rs2_i);
  assign mem_a   = mem_wen_i && (mem_rd_i != '0) && (mem_rd_i == rd_rs1_i);

  a_r6_load_use_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_load_i && (ex_a || ex_b)) |-> (stall_o && bubble_o));

  a_r7_bubble_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  a_r2_ex_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && ex_a) |=> (fwd_a_o == 2'b01));

  a_r3_mem_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && mem_a && !ex_a) |=> (fwd_a_o == 2'b10));

  a_r5_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rs1_i == '0) |=> (fwd_a_o == 2'b00));

  a_r10_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));
endmodule

bind hzd_interlock hzd_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_rs1_i (rd_rs1_i),
  .rd_rs2_i (rd_rs2_i),
  .ex_rd_i  (ex_rd_i),
  .ex_wen_i (ex_wen_i),
  .ex_load_i(ex_load_i),
  .mem_rd_i (mem_rd_i),
  .mem_wen_i(mem_wen_i),
  .stall_o  (stall_o),
  .bubble_o (bubble_o),
  .fwd_a_o  (fwd_a_o),
  .fwd_b_o  (fwd_b_o)
);

// File: tb/hzd_interlock_tb.sv
`timescale 1ns/1ps
module hzd_interlock_tb;
  localparam int unsigned REG_W = 5;

  typedef struct {
    logic       stall;
    logic [1:0] a;
    logic [1:0] b;
    string      req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [REG_W-1:0] rd_rs1_i = '0, rd_rs2_i = '0;
  logic [REG_W-1:0] ex_rd_i = '0, mem_rd_i = '0, wb_rd_i = '0;
  logic ex_wen_i = 1'b0, ex_load_i = 1'b0, mem_wen_i = 1'b0, wb_wen_i = 1'b0;
  logic stall_o, bubble_o;
  logic [1:0] fwd_a_o, fwd_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  hzd_interlock #(.REG_W(REG_W)) u_dut (
    .clk_i, .rst_ni, .rd_rs1_i, .rd_rs2_i,
    .ex_rd_i, .ex_wen_i, .ex_load_i,
    .mem_rd_i, .mem_wen_i, .wb_rd_i, .wb_wen_i,
    .stall_o, .bubble_o, .fwd_a_o, .fwd_b_o
  );

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one cycle of stage inputs; expectation: stall now, selects after the edge
  task automatic drive(
    input logic [REG_W-1:0] rs1, rs2,
    input logic [REG_W-1:0] exd, input logic exw, exl,
    input logic [REG_W-1:0] memd, input logic memw,
    input logic [REG_W-1:0] wbd, input logic wbw,
    input logic st, input logic [1:0] ea, eb, input string req);
    exp_t e;
    @(negedge clk_i);
    rd_rs1_i = rs1; rd_rs2_i = rs2;
    ex_rd_i = exd; ex_wen_i = exw; ex_load_i = exl;
    mem_rd_i = memd; mem_wen_i = memw;
    wb_rd_i = wbd; wb_wen_i = wbw;
    e.stall = st; e.a = ea; e.b = eb; e.req = req;
    q.push_back(e);
  endtask

  // monitor: inputs from the last negedge still stand 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "stall", {1'b0, stall_o}, {1'b0, e.stall});
        check(e.req, "bubble", {1'b0, bubble_o}, {1'b0, e.stall});
        check(e.req, "fwd_a", fwd_a_o, e.a);
        check(e.req, "fwd_b", fwd_b_o, e.b);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "fwd_a in reset", fwd_a_o, 2'b00);
    check("R1", "fwd_b in reset", fwd_b_o, 2'b00);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check("R1", "fwd_a after reset", fwd_a_o, 2'b00);
    check("R1", "stall after reset", {1'b0, stall_o}, 2'b00);

    // R2: execute-stage ALU producer
    drive(5, 7, 5, 1, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00, "R2");
    drive(4, 7, 7, 1, 0, 0, 0, 0, 0, 0, 2'b00, 2'b01, "R2");
    // R3: memory-stage producer
    drive(9, 2, 0, 0, 0, 9, 1, 0, 0, 0, 2'b10, 2'b00, "R3");
    // R4: both stages write r3
    drive(3, 3, 3, 1, 0, 3, 1, 0, 0, 0, 2'b01, 2'b01, "R4");
    // R5: write enable clear, then destination 0 (even as load)
    drive(4, 4, 4, 0, 0, 4, 0, 0, 0, 0, 2'b00, 2'b00, "R5");
    drive(0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 2'b00, 2'b00, "R5");
    // R6/R7: load in execute matches rs2; memory match on rs1 suppressed by bubble
    drive(10, 6, 6, 1, 1, 10, 1, 0, 0, 1, 2'b00, 2'b00, "R6_R7");
    // R8: load moved to memory, bubble in execute
    drive(10, 6, 0, 0, 0, 6, 1, 0, 0, 0, 2'b00, 2'b10, "R8");
    // R6: load matching neither source
    drive(12, 13, 11, 1, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R6");
    // R6: load matching rs1
    drive(14, 1, 14, 1, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, "R6");
    // R9: write-back-only match
    drive(8, 8, 0, 0, 0, 0, 0, 8, 1, 0, 2'b00, 2'b00, "R9");
    // R10: different paths per operand
    drive(1, 2, 1, 1, 0, 2, 1, 0, 0, 0, 2'b01, 2'b10, "R10");
    drive(2, 1, 1, 1, 0, 2, 1, 0, 0, 0, 2'b10, 2'b01, "R10");
    // idle
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R5");

    repeat (3) @(negedge clk_i);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule